// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Engine

This block takes received Ethernet frames as a byte stream and stores them in system memory. It walks a circular chain of descriptors that software places in memory. Each descriptor is four 32-bit words at consecutive word addresses. From the descriptor base these are: control (+0), buffer start (+4), next pointer (+8) and status (+12). A descriptor belongs to the engine only while bit 31 of its status word is set. Once a frame is stored, the engine writes the status word back. That write clears ownership and records the stored length and an error flag. The engine then moves on to the descriptor named by the next pointer.

Software programs the address of the first descriptor into a base register. It then issues a soft reset, which loads that address into the engine's pointer, and a start-fetch strobe. When the engine meets a descriptor it does not own, it stops and waits for another start-fetch strobe. Software can then hand descriptors back and restart the walk. Every completed frame raises a sticky done flag, and this flag drives the interrupt output through an enable bit.

The memory port is a word-wide master. A request is accepted every cycle. Read data appears on `mem_rdata` in the cycle after the read request.

Top module: `rxd_engine`

## Requirements
- R1: After a start-fetch strobe, the engine reads the descriptor words at pointer +0, +4, +8 and +12. If status bit 31 (owned) is set, the engine raises `rx_ready` and stores the frame at the buffer start address, with address bits [1:0] ignored.
- R2: If the fetched status word has bit 31 clear, the engine goes idle. In idle the busy bit (command register bit 0 on read) is 0 and `rx_ready` is 0. The engine stays idle until a start-fetch strobe (write of command register bit 0) refetches the same descriptor.
- R3: Stored bytes are packed little-endian: byte k of the frame goes to lane k mod 4 of the word at buffer + 4·(k div 4). A final partial word is written with only the lanes of stored bytes enabled in `mem_be`.
- R4: After the last byte, the engine writes the status word. Bit 31 is 0, bit 30 is the error flag, bits [12:0] hold the stored byte count and all other bits are 0. An `rx_err` seen on any accepted beat sets bit 30.
- R5: Buffer capacity is control bits [12:0]. Bytes beyond it are accepted and dropped, the stored length is clamped to the capacity, and bit 30 is set.
- R6: After writeback, the pointer takes the next-pointer word with bits [1:0] masked off, so flag bits there have no effect, and the last descriptor may point back to the first.
- R7: If control bit 15 (chain enable) is 0, the engine goes idle after writeback with its pointer already advanced. The next start-fetch strobe resumes there.
- R8: Each writeback sets the done flag (register 2 bit 0), errored frames included. Writing 1 to that bit clears it and writing 0 leaves it set. `irq` is the flag ANDed with register 3 bit 0.
- R9: A soft reset (write of command register bit 1) returns the engine to idle at once and loads the pointer from the base register (register 0, bits [1:0] masked). A frame in progress is dropped without writeback.
- R10: After reset, `irq`, `rx_ready` and `mem_req` are 0 and all readable registers read 0.
- R11: At most one memory access is issued per cycle. Every data write of a frame is issued before its status write, and no other writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 command, 2 done flag, 3 interrupt enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (command reads as the busy bit) |
| rx_valid | input | 1 | Frame byte present |
| rx_ready | output | 1 | Engine accepts a frame byte this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 1 | Frame carries a receive error |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte lane enables of a write |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions guard properties that must hold in every cycle. The memory port is never claimed by the data packer and the descriptor walker at once. The stored count never passes the buffer capacity. A receive phase only begins after an owned status word was read. A soft reset always lands in idle. Written words are aligned and always enable lane 0. Clearing the done flag takes effect on the next cycle. Only the bench scenarios can show what the engine writes to memory and in what order: packed data, clamped lengths, error flags, wrap-around, stopping on unowned or unchained descriptors, and a pointer reloaded after a soft reset. The bench checks these by matching every memory write against a queue of expected writes.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int DW           = 32;
    localparam int BE_W         = DW / 8;
    localparam int ST_OWN_BIT   = 31;
    localparam int ST_ERR_BIT   = 30;
    localparam int CTL_CHAIN_BIT = 15;

    localparam logic [1:0] REG_BASE = 2'd0;
    localparam logic [1:0] REG_CMD  = 2'd1;
    localparam logic [1:0] REG_ISR  = 2'd2;
    localparam logic [1:0] REG_IER  = 2'd3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_RECV,
        S_FLUSH,
        S_WBACK
    } walk_state_t;

    typedef struct packed {
        logic            valid;
        logic            we;
        logic [31:0]     addr;
        logic [DW-1:0]   data;
        logic [BE_W-1:0] be;
    } mem_op_t;

    function automatic logic [BE_W-1:0] lane_mask(input int top_lane);
        logic [BE_W-1:0] m;
        for (int i = 0; i < BE_W; i++) m[i] = (i <= top_lane);
        return m;
    endfunction

endpackage

// File: rtl/rxd_regs.sv
module rxd_regs
    import rxd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    input  logic        done_set,
    input  logic        busy,
    output logic [31:0] rdata,
    output logic [31:0] base_addr,
    output logic        start_p,
    output logic        sreset_p,
    output logic        irq
);

    logic [31:0] base_q;
    logic        isr_q;
    logic        ier_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            isr_q  <= 1'b0;
            ier_q  <= 1'b0;
        end else begin
            if (wr_en && addr == REG_BASE) base_q <= wdata;
            if (wr_en && addr == REG_IER)  ier_q  <= wdata[0];
            if (done_set)
                isr_q <= 1'b1;
            else if (wr_en && addr == REG_ISR && wdata[0])
                isr_q <= 1'b0;
        end
    end

    assign start_p   = wr_en && addr == REG_CMD && wdata[0];
    assign sreset_p  = wr_en && addr == REG_CMD && wdata[1];
    assign base_addr = base_q;
    assign irq       = isr_q & ier_q;

    always_comb begin
        unique case (addr)
            REG_BASE: rdata = base_q;
            REG_CMD:  rdata = {31'b0, busy};
            REG_ISR:  rdata = {31'b0, isr_q};
            default:  rdata = {31'b0, ier_q};
        endcase
    end

    // R8: a write-one-to-clear with no competing completion empties the flag
    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == REG_ISR && wdata[0] && !done_set) |=> !isr_q);

endmodule

// File: rtl/rxd_packer.sv
module rxd_packer
    import rxd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        load,
    input  logic [31:0] load_addr,
    input  logic        push,
    input  logic [7:0]  byte_in,
    input  logic        fin,
    output mem_op_t     op
);

    localparam int LANES = BE_W;
    localparam int LW    = $clog2(LANES);
    localparam logic [LW-1:0] LAST_LANE = LW'(LANES - 1);

    logic [LW-1:0] lane_q;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] merged;
    logic [31:0]   waddr_q;
    mem_op_t       op_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = (lane_q == LW'(g)) ? byte_in : acc_q[g*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lane_q  <= '0;
            acc_q   <= '0;
            waddr_q <= '0;
            op_q    <= '0;
        end else begin
            op_q.valid <= 1'b0;
            if (load) begin
                waddr_q <= load_addr;
                lane_q  <= '0;
                acc_q   <= '0;
            end else if (push && (fin || lane_q == LAST_LANE)) begin
                op_q    <= '{1'b1, 1'b1, waddr_q, merged, lane_mask(int'(lane_q))};
                waddr_q <= waddr_q + 32'(BE_W);
                lane_q  <= '0;
                acc_q   <= '0;
            end else if (push) begin
                acc_q  <= merged;
                lane_q <= lane_q + LW'(1);
            end else if (fin && lane_q != '0) begin
                op_q    <= '{1'b1, 1'b1, waddr_q, acc_q, lane_mask(int'(lane_q) - 1)};
                waddr_q <= waddr_q + 32'(BE_W);
                lane_q  <= '0;
                acc_q   <= '0;
            end
        end
    end

    assign op = op_q;

    // R3: emitted words are aligned and always start at lane 0
    assert_word_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        op_q.valid |-> (op_q.addr[1:0] == 2'b00));
    assert_lane0_first_R3: assert property (@(posedge clk) disable iff (rst)
        op_q.valid |-> op_q.be[0]);

endmodule

// File: rtl/rxd_walker.sv
module rxd_walker
    import rxd_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_p,
    input  logic        sreset_p,
    input  logic [31:0] base_addr,
    input  logic [31:0] mem_rdata,
    input  logic        rx_valid,
    input  logic        rx_last,
    input  logic        rx_err,
    output logic        rx_ready,
    output logic        busy,
    output logic        done_set,
    output logic        pk_load,
    output logic [31:0] pk_load_addr,
    output logic        pk_push,
    output logic        pk_fin,
    output mem_op_t     op
);

    localparam int PAD_W = 30 - LEN_W;

    walk_state_t      state_q;
    logic [31:0]      ptr_q;
    logic [2:0]       fidx_q;
    logic             cap_v_q;
    logic [1:0]       cap_i_q;
    logic [LEN_W-1:0] size_q;
    logic             chain_q;
    logic [29:0]      next_q;
    logic [LEN_W-1:0] cnt_q;
    logic             err_q;
    logic             room;
    logic             accept;
    logic [31:0]      status_w;

    assign rx_ready     = (state_q == S_RECV);
    assign accept       = rx_valid && rx_ready;
    assign room         = cnt_q < size_q;
    assign pk_push      = accept && room;
    assign pk_fin       = accept && rx_last;
    assign pk_load      = (state_q == S_FETCH) && cap_v_q && cap_i_q == 2'd1;
    assign pk_load_addr = {mem_rdata[31:2], 2'b00};
    assign busy         = (state_q != S_IDLE);
    assign done_set     = (state_q == S_WBACK);

    always_comb begin
        status_w                 = '0;
        status_w[ST_ERR_BIT]     = err_q;
        status_w[LEN_W-1:0]      = cnt_q;
    end

    always_comb begin
        op = '0;
        if (state_q == S_FETCH && !fidx_q[2]) begin
            op.valid = 1'b1;
            op.addr  = ptr_q + 32'({fidx_q[1:0], 2'b00});
        end else if (state_q == S_WBACK) begin
            op = '{1'b1, 1'b1, ptr_q + 32'd12, status_w, '1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            ptr_q   <= '0;
            fidx_q  <= '0;
            cap_v_q <= 1'b0;
            cap_i_q <= '0;
            size_q  <= '0;
            chain_q <= 1'b0;
            next_q  <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            cap_v_q <= (state_q == S_FETCH) && !fidx_q[2] && !sreset_p;
            cap_i_q <= fidx_q[1:0];
            if (sreset_p) begin
                state_q <= S_IDLE;
                ptr_q   <= {base_addr[31:2], 2'b00};
            end else begin
                unique case (state_q)
                    S_IDLE: begin
                        if (start_p) begin
                            state_q <= S_FETCH;
                            fidx_q  <= '0;
                        end
                    end
                    S_FETCH: begin
                        if (!fidx_q[2]) fidx_q <= fidx_q + 3'd1;
                        if (cap_v_q) begin
                            unique case (cap_i_q)
                                2'd0: begin
                                    size_q  <= mem_rdata[LEN_W-1:0];
                                    chain_q <= mem_rdata[CTL_CHAIN_BIT];
                                end
                                2'd1: ;
                                2'd2: next_q <= mem_rdata[31:2];
                                default: begin
                                    cnt_q   <= '0;
                                    err_q   <= 1'b0;
                                    state_q <= mem_rdata[ST_OWN_BIT] ? S_RECV : S_IDLE;
                                end
                            endcase
                        end
                    end
                    S_RECV: begin
                        if (accept) begin
                            if (room) cnt_q <= cnt_q + LEN_W'(1);
                            if (!room || rx_err) err_q <= 1'b1;
                            if (rx_last) state_q <= S_FLUSH;
                        end
                    end
                    S_FLUSH: state_q <= S_WBACK;
                    S_WBACK: begin
                        ptr_q   <= {next_q, 2'b00};
                        fidx_q  <= '0;
                        state_q <= chain_q ? S_FETCH : S_IDLE;
                    end
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

    // R5: the stored count never exceeds the buffer capacity
    assert_len_clamp_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RECV) |-> (cnt_q <= size_q));
    // R2: receiving only starts after an owned status word was read
    assert_owned_before_recv_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RECV && $past(state_q) == S_FETCH) |-> $past(mem_rdata[ST_OWN_BIT]));
    // R9: a soft reset always lands in idle
    assert_sreset_idle_R9: assert property (@(posedge clk) disable iff (rst)
        sreset_p |=> (state_q == S_IDLE));

    logic unused_pad;
    assign unused_pad = ^PAD_W;

endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int LEN_W = 13
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_data,
    input  logic        rx_last,
    input  logic        rx_err,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    output logic [3:0]  mem_be,
    input  logic [31:0] mem_rdata,
    output logic        irq
);

    logic        busy, done_set, start_p, sreset_p;
    logic [31:0] base_addr;
    logic        pk_load, pk_push, pk_fin;
    logic [31:0] pk_load_addr;
    mem_op_t     wk_op, pk_op, sel_op;

    rxd_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .done_set(done_set), .busy(busy), .rdata(reg_rdata), .base_addr(base_addr),
        .start_p(start_p), .sreset_p(sreset_p), .irq(irq)
    );

    rxd_walker #(.LEN_W(LEN_W)) u_walker (
        .clk(clk), .rst(rst), .start_p(start_p), .sreset_p(sreset_p),
        .base_addr(base_addr), .mem_rdata(mem_rdata), .rx_valid(rx_valid),
        .rx_last(rx_last), .rx_err(rx_err), .rx_ready(rx_ready), .busy(busy),
        .done_set(done_set), .pk_load(pk_load), .pk_load_addr(pk_load_addr),
        .pk_push(pk_push), .pk_fin(pk_fin), .op(wk_op)
    );

    rxd_packer u_packer (
        .clk(clk), .rst(rst), .clr(sreset_p), .load(pk_load), .load_addr(pk_load_addr),
        .push(pk_push), .byte_in(rx_data), .fin(pk_fin), .op(pk_op)
    );

    assign sel_op    = pk_op.valid ? pk_op : wk_op;
    assign mem_req   = sel_op.valid;
    assign mem_we    = sel_op.we;
    assign mem_addr  = sel_op.addr;
    assign mem_wdata = sel_op.data;
    assign mem_be    = sel_op.be;

    // R11: the packer and the walker never claim the memory port together
    assert_port_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(pk_op.valid && wk_op.valid));

endmodule

// File: tb/test_rxd_engine.sv
module test_rxd_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_err = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] mem_rdata = '0;
    logic        irq;

    always #5 clk = ~clk;

    rxd_engine i_rxd_engine (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata), .irq(irq)
    );

    // bench memory: synchronous, one-cycle read latency
    logic [31:0] ram [0:1023];
    logic        tb_we = 1'b0;
    logic [9:0]  tb_wa = '0;
    logic [31:0] tb_wd = '0;

    always @(posedge clk) begin
        if (tb_we) ram[tb_wa] <= tb_wd;
        if (mem_req) begin
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) ram[mem_addr[11:2]][k*8 +: 8] <= mem_wdata[k*8 +: 8];
            end else begin
                mem_rdata <= ram[mem_addr[11:2]];
            end
        end
    end

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model: queue of writes the engine must issue, in order
    logic [31:0] exp_addr[$];
    logic [31:0] exp_data[$];
    logic [3:0]  exp_be[$];
    string       exp_tag[$];
    logic [7:0]  fb[$];

    logic [31:0] w_a, w_d, w_m;
    logic [3:0]  w_b;
    string       w_t;

    always @(negedge clk) begin
        if (!rst && mem_req && mem_we) begin
            if (exp_addr.size() == 0) begin
                check(1'b0, "R11 unexpected write", mem_addr, 32'hffffffff);
            end else begin
                w_a = exp_addr.pop_front();
                w_d = exp_data.pop_front();
                w_b = exp_be.pop_front();
                w_t = exp_tag.pop_front();
                for (int k = 0; k < 4; k++) w_m[k*8 +: 8] = {8{w_b[k]}};
                check(mem_addr == w_a, {w_t, " addr"}, mem_addr, w_a);
                check(mem_be == w_b, {w_t, " byte enables"}, {28'b0, mem_be}, {28'b0, w_b});
                check((mem_wdata & w_m) == (w_d & w_m), {w_t, " data"}, mem_wdata & w_m, w_d & w_m);
            end
        end
    end

    task automatic make_bytes(input int n, input int seed);
        fb.delete();
        for (int i = 0; i < n; i++) fb.push_back(8'((seed + i * 37) & 255));
    endtask

    task automatic expect_frame(input logic [31:0] desc, input logic [31:0] bufa,
                                input int size, input bit err, input string st_tag);
        int n = fb.size();
        int stored = (n < size) ? n : size;
        logic [31:0] d;
        logic [3:0]  b;
        for (int w = 0; w * 4 < stored; w++) begin
            d = '0;
            b = '0;
            for (int k = 0; k < 4; k++) begin
                if (w * 4 + k < stored) begin
                    d[k*8 +: 8] = fb[w * 4 + k];
                    b[k] = 1'b1;
                end
            end
            exp_addr.push_back(bufa + 32'(w * 4));
            exp_data.push_back(d);
            exp_be.push_back(b);
            exp_tag.push_back("R1 R3 packed word");
        end
        exp_addr.push_back(desc + 32'd12);
        exp_data.push_back(((err || n > size) ? 32'h4000_0000 : 32'h0) | 32'(stored));
        exp_be.push_back(4'hf);
        exp_tag.push_back(st_tag);
    endtask

    task automatic send_frame(input bit err, input bit with_last);
        int i = 0;
        int n = fb.size();
        while (i < n) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = fb[i];
            rx_last  = with_last && (i == n - 1);
            rx_err   = err && (i == n - 1);
            if (rx_ready) i++;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_last  = 1'b0;
        rx_err   = 1'b0;
    endtask

    task automatic wait_drain();
        int t = 0;
        while (exp_addr.size() != 0 && t < 300) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic tb_poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1;
        tb_wa = a[11:2];
        tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic finish_run();
        check(exp_addr.size() == 0, "R11 missing writes", 32'(exp_addr.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    localparam logic [31:0] D0 = 32'h100, D1 = 32'h110, D2 = 32'h120;
    localparam logic [31:0] B0 = 32'h200, B1 = 32'h280, B2 = 32'h300;
    localparam logic [31:0] CHAIN = 32'h0000_8000, OWN = 32'h8000_0000;

    initial begin
        logic [31:0] rv;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(irq == 1'b0, "R10 irq after reset", {31'b0, irq}, 32'd0);
        check(rx_ready == 1'b0, "R10 rx_ready after reset", {31'b0, rx_ready}, 32'd0);
        check(mem_req == 1'b0, "R10 mem_req after reset", {31'b0, mem_req}, 32'd0);
        for (int r = 0; r < 4; r++) begin
            reg_rd(2'(r), rv);
            check(rv == 32'd0, "R10 register after reset", rv, 32'd0);
        end

        // three-descriptor ring; next pointers carry a flag in bit 0 (R6 masks it)
        tb_poke(D0 + 0, CHAIN | 32'd64); tb_poke(D0 + 4, B0); tb_poke(D0 + 8, D1 | 32'd1); tb_poke(D0 + 12, OWN);
        tb_poke(D1 + 0, CHAIN | 32'd6);  tb_poke(D1 + 4, B1 | 32'd2); tb_poke(D1 + 8, D2 | 32'd1); tb_poke(D1 + 12, OWN);
        tb_poke(D2 + 0, CHAIN | 32'd64); tb_poke(D2 + 4, B2); tb_poke(D2 + 8, D0 | 32'd1); tb_poke(D2 + 12, OWN);

        reg_wr(2'd0, D0 | 32'd1);
        reg_wr(2'd3, 32'd1);
        reg_wr(2'd1, 32'd2);
        reg_wr(2'd1, 32'd1);
        repeat (8) @(negedge clk);
        check(rx_ready == 1'b1, "R1 owned descriptor opens receive", {31'b0, rx_ready}, 32'd1);

        // frame A: 7 bytes, partial final word
        make_bytes(7, 5);
        expect_frame(D0, B0, 64, 1'b0, "R4 status clean");
        send_frame(1'b0, 1'b1);
        wait_drain();
        check(irq == 1'b1, "R8 irq after done", {31'b0, irq}, 32'd1);
        reg_rd(2'd2, rv);
        check(rv == 32'd1, "R8 done flag set", rv, 32'd1);
        reg_wr(2'd2, 32'd1);
        @(negedge clk);
        check(irq == 1'b0, "R8 irq cleared by W1C", {31'b0, irq}, 32'd0);

        // frame B: 9 bytes into a 6-byte buffer
        make_bytes(9, 77);
        expect_frame(D1, B1, 6, 1'b0, "R5 clamped status");
        send_frame(1'b0, 1'b1);
        wait_drain();

        // frame C: error flag
        make_bytes(5, 140);
        expect_frame(D2, B2, 64, 1'b1, "R4 error status");
        send_frame(1'b1, 1'b1);
        wait_drain();
        check(irq == 1'b1, "R8 errored frame sets done", {31'b0, irq}, 32'd1);

        // ring wraps to D0, which software has not returned: idle
        repeat (10) @(negedge clk);
        reg_rd(2'd1, rv);
        check(rv == 32'd0, "R2 idle on unowned descriptor", rv, 32'd0);
        check(rx_ready == 1'b0, "R2 no intake while idle", {31'b0, rx_ready}, 32'd0);

        // return descriptors; D1 unchained
        tb_poke(D0 + 12, OWN);
        tb_poke(D1 + 0, 32'd64);
        tb_poke(D1 + 12, OWN);
        tb_poke(D2 + 12, OWN);
        reg_wr(2'd1, 32'd1);

        make_bytes(4, 201);
        expect_frame(D0, B0, 64, 1'b0, "R6 wrapped status");
        send_frame(1'b0, 1'b1);
        wait_drain();

        make_bytes(2, 33);
        expect_frame(D1, B1, 64, 1'b0, "R7 unchained status");
        send_frame(1'b0, 1'b1);
        wait_drain();
        repeat (6) @(negedge clk);
        reg_rd(2'd1, rv);
        check(rv == 32'd0, "R7 idle after unchained descriptor", rv, 32'd0);
        check(rx_ready == 1'b0, "R7 no intake after unchained", {31'b0, rx_ready}, 32'd0);

        reg_wr(2'd1, 32'd1);
        repeat (8) @(negedge clk);
        check(rx_ready == 1'b1, "R7 start resumes at next descriptor", {31'b0, rx_ready}, 32'd1);

        // partial frame then soft reset: no writeback expected
        make_bytes(3, 90);
        send_frame(1'b0, 1'b0);
        reg_wr(2'd1, 32'd2);
        reg_rd(2'd1, rv);
        check(rv == 32'd0, "R9 soft reset idles", rv, 32'd0);
        check(rx_ready == 1'b0, "R9 no intake after soft reset", {31'b0, rx_ready}, 32'd0);

        reg_wr(2'd2, 32'd1);
        reg_wr(2'd3, 32'd0);
        tb_poke(D0 + 12, OWN);
        reg_wr(2'd1, 32'd1);
        make_bytes(1, 17);
        expect_frame(D0, B0, 64, 1'b0, "R9 reloaded pointer status");
        send_frame(1'b0, 1'b1);
        wait_drain();
        check(irq == 1'b0, "R8 irq masked", {31'b0, irq}, 32'd0);
        reg_rd(2'd2, rv);
        check(rv == 32'd1, "R8 flag set while masked", rv, 32'd1);
        reg_wr(2'd2, 32'd0);
        reg_rd(2'd2, rv);
        check(rv == 32'd1, "R8 write of zero keeps flag", rv, 32'd1);
        reg_wr(2'd2, 32'd1);
        reg_rd(2'd2, rv);
        check(rv == 32'd0, "R8 write of one clears flag", rv, 32'd0);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule